// File: doc/BRIEF.md
# Pointer-Based Register Bank in Shared Data RAM

This block provides sixteen general-purpose registers that have no storage of their own. Every register is one word of an on-chip data RAM. Register number n maps to the RAM word at base + n, where base is a programmable context pointer. A core reads two registers and writes one register per cycle through 4-bit register numbers. A separate memory port reads and writes the same RAM by absolute address.

A task switch is a single write to the context pointer. The new pointer takes effect on the next cycle, and no register contents are copied. The old register set stays in RAM where it was, so it can be reached again later or inspected through the memory port. A pointer value that would put R15 past the last RAM word is refused, and an error flag reports the refusal.

Top module: `ctxreg_bank`

## Requirements
- R1: After synchronous reset the context pointer is 0, the error flag is 0, and all three read-data outputs are 0.
- R2: Register n (0 to 15) is the RAM word at pointer + n. Read data for a register number presented in one cycle appears on the output in the next cycle.
- R3: The memory port reaches the same words by absolute address. A write through either port is seen by a read through the other port that is issued in the following cycle.
- R4: A pointer write is used from the next cycle on. A register access in the same cycle as the pointer write still uses the old pointer.
- R5: The RAM has 256 words, so the largest accepted pointer is 240. A pointer write above 240 leaves the pointer unchanged and sets the error flag. An accepted pointer write clears the flag. The flag changes only on a pointer write.
- R6: If the register port and the memory port write the same RAM word in one cycle, the word keeps the register-port data. Writes to different words in one cycle both take effect.
- R7: Changing the pointer moves no data. When the pointer returns to an earlier value, the registers read back what was written under that value.
- R8: The two register read ports are independent. In the same cycle they return the contents of two different registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_num | input | 4 | Register number for read port A |
| rd_a_data | output | 16 | Registered read data, port A |
| rd_b_num | input | 4 | Register number for read port B |
| rd_b_data | output | 16 | Registered read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_num | input | 4 | Register number to write |
| wr_data | input | 16 | Register write data |
| mem_we | input | 1 | Memory-port write enable |
| mem_addr | input | 8 | Absolute RAM address |
| mem_wdata | input | 16 | Memory-port write data |
| mem_rdata | output | 16 | Registered memory-port read data |
| cp_we | input | 1 | Context pointer write enable |
| cp_wdata | input | 8 | New context pointer value |
| cp_q | output | 8 | Current context pointer |
| cp_err | output | 1 | Set by the last refused pointer write |

## Verification
The hardest cases to reach from the ports are those that depend on two events in one cycle. One is a register write and a memory write that hit the same word. The other is a pointer write together with a register read. For each, the bench drives both inputs at the same falling edge. It then reads the result through the memory port or through the read ports at later edges. To cover the pointer limit, the bench writes 240, 241 and 255 and then writes R15 at the top RAM word.

// File: rtl/ctxreg_pkg.sv
package ctxreg_pkg;
  typedef enum logic [1:0] {
    CP_HOLD   = 2'd0,
    CP_LOAD   = 2'd1,
    CP_REFUSE = 2'd2
  } cp_action_e;
endpackage

// File: rtl/ctxreg_ptr.sv
module ctxreg_ptr
  import ctxreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic              err_q
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LIMIT = DEPTH - NREG;

  cp_action_e act;

  always_comb begin
    if (!we)                      act = CP_HOLD;
    else if (int'(wdata) > LIMIT) act = CP_REFUSE;
    else                          act = CP_LOAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (act)
        CP_LOAD: begin
          base_q <= wdata;
          err_q  <= 1'b0;
        end
        CP_REFUSE: err_q <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctxreg_xlate.sv
module ctxreg_xlate #(
  parameter int ADDR_W = 8,
  parameter int NUM_W  = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [NUM_W-1:0]  num,
  output logic [ADDR_W-1:0] addr
);
  always_comb addr = base + ADDR_W'(num);
endmodule

// File: rtl/ctxreg_store.sv
module ctxreg_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NRD    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NRD-1:0][ADDR_W-1:0]    raddr,
  output logic [NRD-1:0][DATA_W-1:0]    rdata,
  input  logic                          lo_we,
  input  logic [ADDR_W-1:0]             lo_addr,
  input  logic [DATA_W-1:0]             lo_wdata,
  input  logic                          hi_we,
  input  logic [ADDR_W-1:0]             hi_addr,
  input  logic [DATA_W-1:0]             hi_wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  // The later assignment takes priority: the hi port wins a same-word conflict.
  always_ff @(posedge clk) begin
    if (lo_we) ram[lo_addr] <= lo_wdata;
    if (hi_we) ram[hi_addr] <= hi_wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) rdata[p] <= '0;
      else     rdata[p] <= ram[raddr[p]];
    end
  end
endmodule

// File: rtl/ctxreg_bank.sv
module ctxreg_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  localparam int NUM_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_W-1:0]  rd_a_num,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [NUM_W-1:0]  rd_b_num,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [NUM_W-1:0]  wr_num,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic              cp_we,
  input  logic [ADDR_W-1:0] cp_wdata,
  output logic [ADDR_W-1:0] cp_q,
  output logic              cp_err
);
  localparam int NRD = 3;

  logic [ADDR_W-1:0]             base;
  logic [2:0][NUM_W-1:0]         nums;
  logic [2:0][ADDR_W-1:0]        xaddr;
  logic [NRD-1:0][ADDR_W-1:0]    raddr;
  logic [NRD-1:0][DATA_W-1:0]    rdata;

  ctxreg_ptr #(.ADDR_W(ADDR_W), .NREG(NREG)) ptr_i (
    .clk(clk), .rst(rst), .we(cp_we), .wdata(cp_wdata),
    .base_q(base), .err_q(cp_err)
  );

  // Lanes: 0 = read A, 1 = read B, 2 = write.
  assign nums[0] = rd_a_num;
  assign nums[1] = rd_b_num;
  assign nums[2] = wr_num;

  for (genvar i = 0; i < 3; i++) begin : g_xl
    ctxreg_xlate #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) xl_i (
      .base(base), .num(nums[i]), .addr(xaddr[i])
    );
  end

  assign raddr[0] = xaddr[0];
  assign raddr[1] = xaddr[1];
  assign raddr[2] = mem_addr;

  ctxreg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NRD)) store_i (
    .clk(clk), .rst(rst), .raddr(raddr), .rdata(rdata),
    .lo_we(mem_we), .lo_addr(mem_addr), .lo_wdata(mem_wdata),
    .hi_we(wr_en), .hi_addr(xaddr[2]), .hi_wdata(wr_data)
  );

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];
  assign mem_rdata = rdata[2];
  assign cp_q      = base;
endmodule

// File: rtl/ctxreg_bank_chk.sv
module ctxreg_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cp_we,
  input logic [ADDR_W-1:0] cp_wdata,
  input logic [ADDR_W-1:0] cp_q,
  input logic              cp_err
);
  localparam int LIMIT = (1 << ADDR_W) - NREG;

  assert_cp_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    int'(cp_q) <= LIMIT);

  assert_refuse_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (cp_we && int'(cp_wdata) > LIMIT) |=> (cp_err && $stable(cp_q)));

  assert_accept_loads_R4: assert property (@(posedge clk) disable iff (rst)
    (cp_we && int'(cp_wdata) <= LIMIT) |=> (!cp_err && cp_q == $past(cp_wdata)));

  assert_cp_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !cp_we |=> $stable(cp_q));

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !cp_we |=> $stable(cp_err));
endmodule

bind ctxreg_bank ctxreg_bank_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) chk_i (
  .clk(clk), .rst(rst), .cp_we(cp_we), .cp_wdata(cp_wdata),
  .cp_q(cp_q), .cp_err(cp_err)
);

// File: tb/ctxreg_bank_tb_top.sv
module ctxreg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_a_num, rd_b_num, wr_num;
  logic [15:0] rd_a_data, rd_b_data, wr_data, mem_wdata, mem_rdata;
  logic        wr_en, mem_we, cp_we, cp_err;
  logic [7:0]  mem_addr, cp_wdata, cp_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ctxreg_bank dut_i (
    .clk(clk), .rst(rst),
    .rd_a_num(rd_a_num), .rd_a_data(rd_a_data),
    .rd_b_num(rd_b_num), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .cp_we(cp_we), .cp_wdata(cp_wdata), .cp_q(cp_q), .cp_err(cp_err)
  );

  // Table: pointer, register number, data.
  localparam int NV = 6;
  localparam logic [7:0]  V_CP  [NV] = '{8'd0, 8'd16, 8'd100, 8'd200, 8'd240, 8'd7};
  localparam logic [3:0]  V_REG [NV] = '{4'd0, 4'd15, 4'd9, 4'd3, 4'd15, 4'd1};
  localparam logic [15:0] V_DAT [NV] = '{16'hA5A5, 16'h0F0F, 16'h1234,
                                         16'hFFFF, 16'h8001, 16'h00C3};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; mem_we = 0; cp_we = 0;
  endtask

  task automatic set_cp(logic [7:0] v);
    @(negedge clk); cp_we = 1; cp_wdata = v;
    @(negedge clk); cp_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; idle();
    rd_a_num = 0; rd_b_num = 0; wr_num = 0; wr_data = 0;
    mem_addr = 0; mem_wdata = 0; cp_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state (RAM contents unknown, so check before any read cycle).
    rst = 1; @(negedge clk);
    check("R1 cp", {8'd0, cp_q}, 16'd0);
    check("R1 err", {15'd0, cp_err}, 16'd0);
    check("R1 rdA", rd_a_data, 16'd0);
    check("R1 rdB", rd_b_data, 16'd0);
    check("R1 mem", mem_rdata, 16'd0);
    rst = 0;

    // R2/R3: table walk, register write then read by both paths.
    for (int i = 0; i < NV; i++) begin
      set_cp(V_CP[i]);
      check("R5 table cp", {8'd0, cp_q}, {8'd0, V_CP[i]});
      wr_en = 1; wr_num = V_REG[i]; wr_data = V_DAT[i];
      @(negedge clk); idle();
      rd_a_num = V_REG[i]; mem_addr = V_CP[i] + 8'(V_REG[i]);
      @(negedge clk);
      check("R2 table reg read", rd_a_data, V_DAT[i]);
      check("R3 table mem read", mem_rdata, V_DAT[i]);
    end

    // R8: two read ports in one cycle.
    set_cp(8'd64);
    wr_en = 1; wr_num = 1; wr_data = 16'h1111;
    @(negedge clk); wr_num = 2; wr_data = 16'h2222;
    @(negedge clk); idle(); rd_a_num = 1; rd_b_num = 2;
    @(negedge clk);
    check("R8 portA", rd_a_data, 16'h1111);
    check("R8 portB", rd_b_data, 16'h2222);

    // R6: same-word conflict, register port wins; different words both land.
    set_cp(8'd32);
    wr_en = 1; wr_num = 5; wr_data = 16'hAAAA;
    mem_we = 1; mem_addr = 8'd37; mem_wdata = 16'hBBBB;
    @(negedge clk);
    wr_num = 6; wr_data = 16'h4444; mem_addr = 8'd40; mem_wdata = 16'h3333;
    @(negedge clk); idle(); mem_addr = 8'd37;
    @(negedge clk);
    check("R6 conflict", mem_rdata, 16'hAAAA);
    mem_addr = 8'd38; @(negedge clk);
    check("R6 reg side", mem_rdata, 16'h4444);
    mem_addr = 8'd40; @(negedge clk);
    check("R6 mem side", mem_rdata, 16'h3333);

    // R3: memory write seen by register read in the next cycle.
    mem_we = 1; mem_addr = 8'd34; mem_wdata = 16'h7777;
    @(negedge clk); idle(); rd_a_num = 2;
    @(negedge clk);
    check("R3 mem->reg", rd_a_data, 16'h7777);

    // R4: pointer write with a read in the same cycle uses the old pointer.
    mem_we = 1; mem_addr = 8'd53; mem_wdata = 16'h5555;
    @(negedge clk); idle();
    cp_we = 1; cp_wdata = 8'd48; rd_a_num = 5;
    @(negedge clk); cp_we = 0;
    check("R4 same-cycle old cp", rd_a_data, 16'hAAAA);
    @(negedge clk);
    check("R4 next-cycle new cp", rd_a_data, 16'h5555);

    // R5: limit handling.
    set_cp(8'd241);
    check("R5 refuse keeps cp", {8'd0, cp_q}, 16'd48);
    check("R5 refuse sets err", {15'd0, cp_err}, 16'd1);
    @(negedge clk);
    check("R5 err holds", {15'd0, cp_err}, 16'd1);
    set_cp(8'd240);
    check("R5 accept 240", {8'd0, cp_q}, 16'd240);
    check("R5 accept clears err", {15'd0, cp_err}, 16'd0);
    wr_en = 1; wr_num = 15; wr_data = 16'hBEEF;
    @(negedge clk); idle(); mem_addr = 8'd255;
    @(negedge clk);
    check("R5 R15 at top word", mem_rdata, 16'hBEEF);
    set_cp(8'd255);
    check("R5 refuse 255", {8'd0, cp_q}, 16'd240);
    check("R5 err on 255", {15'd0, cp_err}, 16'd1);

    // R7: returning to an earlier pointer finds the earlier contents.
    set_cp(8'd32);
    rd_a_num = 5; rd_b_num = 2;
    @(negedge clk);
    check("R7 R5 restored", rd_a_data, 16'hAAAA);
    check("R7 R2 restored", rd_b_data, 16'h7777);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule